// File: doc/BRIEF.md
# Cascaded Dual-Controller DMA Transfer Sequencer

This block sequences single DMA transfer cycles for eight channels split across two four-channel controllers. Channels 0 to 3 move bytes; channels 4 to 7 move 16-bit words. The word controller's slot 0 (channel 4) is permanently tied to the byte controller as its cascade input. Any unmasked byte-side request shows up as a cascade request. Any pending request on the word side raises a hold request towards the bus owner.

When the bus owner acknowledges the hold, the block picks one channel and runs exactly one transfer cycle for it. It drives the physical address, the size flag, the memory strobes and the channel acknowledge. It then steps that channel's address and count, and handles terminal count, auto-reload and self-masking. Each channel is programmed through a simple load port. A load sets the transfer kind, the address direction, auto-reload, the mask, the base address, the base count and the page.

Top module: `dual_dma_seq`

## Requirements
- R1: After synchronous reset every channel is masked and hold_req_o, casc_req_o, ack_o, term_cnt_o, mem_rd_o, mem_wr_o, tc_status_o and err_o are all zero.
- R2: An attached, unmasked request on a byte channel (0..3) drives casc_req_o and hold_req_o high in the same cycle. A request on a masked channel drives neither.
- R3: On acceptance the word side is scanned in the order cascade slot, 5, 6, 7. If the cascade slot wins, the byte side is scanned 0, 1, 2, 3. The lowest pending index wins, so any byte request beats channels 5 to 7.
- R4: A transfer is accepted on a rising edge where the block is idle, hold_ack_i is high and a request is pending. ack_o is high for exactly the next cycle: bit c for the winner, plus bit 4 when the winner is a byte channel. In the cycle after that, hold_req_o is low.
- R5: mem_addr_o is {page, 16 zero bits} ORed with the current address, and the current address is shifted left by one for word channels. word_o is high for channels 4 to 7.
- R6: Kind 1 asserts mem_wr_o with mem_wdata_o equal to the device data (upper byte zero on byte channels). Kind 2 asserts mem_rd_o with dev_data_o equal to the memory data. Kinds 0 (verify) and 3 assert neither strobe.
- R7: Each transfer decrements the current count. It increments the current address, or decrements it when the direction bit is set.
- R8: A transfer made while the current count is 0 raises term_cnt_o together with ack_o and sets the channel's bit in tc_status_o. That bit stays set until the channel is loaded again.
- R9: On terminal count without auto-reload the channel masks itself, so its request no longer raises hold_req_o.
- R10: On terminal count with auto-reload the current address and count return to their base values and the channel stays unmasked.
- R11: A request on channel 4, or on a channel whose attached_i bit is 0, is ignored for arbitration and sets err_o, which stays set until reset.
- R12: A load whose channel number is 4 or above 7 changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Per-channel transfer request |
| attached_i | input | 8 | Per-channel device-present flag |
| hold_ack_i | input | 1 | Bus owner grants the hold |
| hold_req_o | output | 1 | Hold request to the bus owner |
| casc_req_o | output | 1 | Byte controller request into cascade slot |
| ack_o | output | 8 | Per-channel acknowledge (bit 4 = cascade) |
| term_cnt_o | output | 1 | Terminal count, valid with ack_o |
| tc_status_o | output | 8 | Held per-channel terminal-count flags |
| err_o | output | 1 | Sticky illegal-request flag |
| mem_addr_o | output | PAGE_W+ADDR_W | Physical memory address |
| word_o | output | 1 | High for 16-bit transfers |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| dev_data_i | input | DATA_W | Data from the device |
| mem_wdata_o | output | DATA_W | Data written to memory |
| mem_rdata_i | input | DATA_W | Data read from memory |
| dev_data_o | output | DATA_W | Data sent to the device |
| cfg_we_i | input | 1 | Channel load strobe |
| cfg_ch_i | input | 4 | Channel to load |
| cfg_type_i | input | 2 | Transfer kind |
| cfg_dec_i | input | 1 | Address steps downward |
| cfg_auto_i | input | 1 | Auto-reload at terminal count |
| cfg_mask_i | input | 1 | Mask value to load |
| cfg_addr_i | input | ADDR_W | Base and current address |
| cfg_count_i | input | CNT_W | Base and current count |
| cfg_page_i | input | PAGE_W | Page bits |

## Verification
The hardest state to reach is the end of a word channel's auto-reload run while a masked-out byte channel still holds its request. It needs a byte channel driven to terminal count first, so its self-mask hands the bus to the word channel. The word channel then has to be walked through its own expiry and one more transfer. The stimulus runs the two channels back to back, granting one transfer at a time. A scoreboard predicts every acknowledge, address and data word. A load to an out-of-range channel whose low bits alias the masked byte channel then shows at hold_req_o and tc_status_o that nothing changed.

// File: rtl/dma_seq_pkg.sv
// Shared types for the dual DMA sequencer.
// Assumes a fixed split of eight channels into two controllers of four.
package dma_seq_pkg;
    localparam int CH_PER  = 4;
    localparam int NCH     = 2 * CH_PER;
    localparam int CASC_CH = CH_PER;

    typedef enum logic [1:0] {
        XF_VERIFY   = 2'd0,
        XF_TO_MEM   = 2'd1,
        XF_FROM_MEM = 2'd2,
        XF_RSVD     = 2'd3
    } xfer_e;

    typedef struct packed {
        xfer_e kind;
        logic  down;
        logic  reload;
    } chan_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dma_pri_pick.sv
// Fixed-priority picker: lowest set index wins.
// Assumes N is a power of two.
module dma_pri_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Scan from the top down so the lowest pending index is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |pend_i;
endmodule

// File: rtl/dma_chan_ctx.sv
// Per-channel programmed state: base/current address and count, page, mode,
// mask and held terminal-count flag. Assumes load and step never coincide
// in a meaningful way (load wins).
module dma_chan_ctx
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  chan_mode_t        mode_i,
    input  logic              mask_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  cur_cnt_o,
    output logic [PAGE_W-1:0] page_o,
    output xfer_e             kind_o,
    output logic              mask_o,
    output logic              tc_o
);
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    chan_mode_t        mode_q;
    logic [ADDR_W-1:0] next_addr;
    logic              expire;

    assign next_addr = mode_q.down ? cur_addr_o - 1'b1 : cur_addr_o + 1'b1;
    assign expire    = (cur_cnt_o == '0);

    // Load programming, or advance address/count after one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr  <= '0;
            base_cnt   <= '0;
            cur_addr_o <= '0;
            cur_cnt_o  <= '0;
            page_o     <= '0;
            mode_q     <= '0;
            mask_o     <= 1'b1;
            tc_o       <= 1'b0;
        end else if (load_i) begin
            base_addr  <= addr_i;
            base_cnt   <= cnt_i;
            cur_addr_o <= addr_i;
            cur_cnt_o  <= cnt_i;
            page_o     <= page_i;
            mode_q     <= mode_i;
            mask_o     <= mask_i;
            tc_o       <= 1'b0;
        end else if (step_i) begin
            if (expire) begin
                tc_o <= 1'b1;
                if (mode_q.reload) begin
                    cur_addr_o <= base_addr;
                    cur_cnt_o  <= base_cnt;
                end else begin
                    mask_o     <= 1'b1;
                    cur_addr_o <= next_addr;
                    cur_cnt_o  <= cur_cnt_o - 1'b1;
                end
            end else begin
                cur_addr_o <= next_addr;
                cur_cnt_o  <= cur_cnt_o - 1'b1;
            end
        end
    end

    assign kind_o = mode_q.kind;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !expire) |=> (cur_cnt_o == $past(cur_cnt_o) - 1'b1)); // R7
    AST_EXPIRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && expire && !mode_q.reload) |=> mask_o); // R9
    AST_RELOAD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && expire && mode_q.reload && !mask_o) |=> (!mask_o && tc_o)); // R10
    AST_TC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !load_i) |=> tc_o); // R8
endmodule

// File: rtl/dual_dma_seq.sv
// Two cascaded four-channel DMA controllers: byte channels 0..3 feed the
// cascade slot (channel 4) of the word controller (channels 4..7).
// One transfer cycle per accepted hold acknowledge, then a one-cycle gap
// with the hold request low. Assumes the bus owner supplies/consumes data
// combinationally during the transfer cycle.
module dual_dma_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               req_i,
    input  logic [7:0]               attached_i,
    input  logic                     hold_ack_i,
    output logic                     hold_req_o,
    output logic                     casc_req_o,
    output logic [7:0]               ack_o,
    output logic                     term_cnt_o,
    output logic [7:0]               tc_status_o,
    output logic                     err_o,
    output logic [PAGE_W+ADDR_W-1:0] mem_addr_o,
    output logic                     word_o,
    output logic                     mem_rd_o,
    output logic                     mem_wr_o,
    input  logic [DATA_W-1:0]        dev_data_i,
    output logic [DATA_W-1:0]        mem_wdata_o,
    input  logic [DATA_W-1:0]        mem_rdata_i,
    output logic [DATA_W-1:0]        dev_data_o,
    input  logic                     cfg_we_i,
    input  logic [3:0]               cfg_ch_i,
    input  logic [1:0]               cfg_type_i,
    input  logic                     cfg_dec_i,
    input  logic                     cfg_auto_i,
    input  logic                     cfg_mask_i,
    input  logic [ADDR_W-1:0]        cfg_addr_i,
    input  logic [CNT_W-1:0]         cfg_count_i,
    input  logic [PAGE_W-1:0]        cfg_page_i
);
    localparam int PHYS_W = PAGE_W + ADDR_W;
    localparam int HALF_W = DATA_W / 2;
    localparam int SEL_W  = $clog2(NCH);
    localparam int PIW    = $clog2(CH_PER);
    localparam logic [NCH-1:0] CASC_BIT = NCH'(1) << CASC_CH;

    logic [ADDR_W-1:0] cur_addr [NCH];
    logic [CNT_W-1:0]  cur_cnt  [NCH];
    logic [PAGE_W-1:0] page     [NCH];
    xfer_e             kind     [NCH];
    logic [NCH-1:0]    mask_v, tc_v, load_v, step_v;

    seq_state_e        state;
    logic [SEL_W-1:0]  win_q, win_d;
    logic              xfer;
    chan_mode_t        cfg_mode;

    logic [NCH-1:0]    legal, live;
    logic [CH_PER-1:0] pend_lo, pend_hi;
    logic [PIW-1:0]    idx_lo, idx_hi;
    logic              any_lo, any_hi;
    logic              err_q;

    assign cfg_mode = '{kind: xfer_e'(cfg_type_i), down: cfg_dec_i, reload: cfg_auto_i};
    assign xfer     = (state == ST_XFER);

    // One context per channel; the cascade slot is never loadable.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == CASC_CH) begin : g_casc
            assign load_v[c] = 1'b0;
        end else begin : g_dev
            assign load_v[c] = cfg_we_i && (cfg_ch_i == 4'(c));
        end
        assign step_v[c] = xfer && (win_q == SEL_W'(c));

        dma_chan_ctx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) ctx_i (
            .clk(clk), .rst_n(rst_n), .load_i(load_v[c]), .mode_i(cfg_mode),
            .mask_i(cfg_mask_i), .addr_i(cfg_addr_i), .cnt_i(cfg_count_i),
            .page_i(cfg_page_i), .step_i(step_v[c]), .cur_addr_o(cur_addr[c]),
            .cur_cnt_o(cur_cnt[c]), .page_o(page[c]), .kind_o(kind[c]),
            .mask_o(mask_v[c]), .tc_o(tc_v[c])
        );
    end

    assign legal      = req_i & attached_i & ~CASC_BIT;
    assign live       = legal & ~mask_v;
    assign pend_lo    = live[CH_PER-1:0];
    assign pend_hi    = live[NCH-1:CH_PER] | {{(CH_PER-1){1'b0}}, any_lo};
    assign casc_req_o = any_lo;
    assign hold_req_o = any_hi && (state != ST_GAP);

    dma_pri_pick #(.N(CH_PER)) pick_lo_i (.pend_i(pend_lo), .idx_o(idx_lo), .any_o(any_lo));
    dma_pri_pick #(.N(CH_PER)) pick_hi_i (.pend_i(pend_hi), .idx_o(idx_hi), .any_o(any_hi));

    assign win_d = (idx_hi == '0) ? {1'b0, idx_lo} : {1'b1, idx_hi};

    // Sequence: accept on hold acknowledge, one transfer cycle, one gap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            win_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (hold_ack_i && any_hi) begin
                    state <= ST_XFER;
                    win_q <= win_d;
                end
                ST_XFER: state <= ST_GAP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky flag for requests on the cascade slot or on absent devices.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (|(req_i & ~(attached_i & ~CASC_BIT)));
    end
    assign err_o = err_q;

    // Acknowledge the winner, plus the cascade slot for a byte channel.
    always_comb begin
        ack_o = '0;
        if (xfer) begin
            ack_o[win_q] = 1'b1;
            if (!win_q[SEL_W-1]) ack_o[CASC_CH] = 1'b1;
        end
    end

    assign word_o      = xfer && win_q[SEL_W-1];
    assign term_cnt_o  = xfer && (cur_cnt[win_q] == '0);
    assign mem_addr_o  = xfer ? (({page[win_q], {ADDR_W{1'b0}}})
                               | ({{PAGE_W{1'b0}}, cur_addr[win_q]} << word_o)) : '0;
    assign mem_wr_o    = xfer && (kind[win_q] == XF_TO_MEM);
    assign mem_rd_o    = xfer && (kind[win_q] == XF_FROM_MEM);
    assign mem_wdata_o = !mem_wr_o ? '0 :
                         word_o ? dev_data_i : {{HALF_W{1'b0}}, dev_data_i[HALF_W-1:0]};
    assign dev_data_o  = !mem_rd_o ? '0 :
                         word_o ? mem_rdata_i : {{HALF_W{1'b0}}, mem_rdata_i[HALF_W-1:0]};
    assign tc_status_o = tc_v;

    AST_CASC_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o[CH_PER-1:0]) |-> ack_o[CASC_CH]); // R4
    AST_ACK_NEEDS_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> $past(hold_ack_i)); // R4
    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |=> !hold_req_o); // R4
    AST_SINGLE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ack_o) <= 2); // R3
    AST_TC_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt_o |-> (|ack_o)); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R11
endmodule

// File: tb/dual_dma_seq_tb_top.sv
module dual_dma_seq_tb_top;
    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [7:0]  req_i, attached_i, ack_o, tc_status_o;
    logic        hold_ack_i, hold_req_o, casc_req_o, term_cnt_o, err_o;
    logic [23:0] mem_addr_o;
    logic        word_o, mem_rd_o, mem_wr_o;
    logic [15:0] dev_data_i, mem_wdata_o, mem_rdata_i, dev_data_o;
    logic        cfg_we_i, cfg_dec_i, cfg_auto_i, cfg_mask_i;
    logic [3:0]  cfg_ch_i;
    logic [1:0]  cfg_type_i;
    logic [15:0] cfg_addr_i, cfg_count_i;
    logic [7:0]  cfg_page_i;

    dual_dma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .attached_i(attached_i),
        .hold_ack_i(hold_ack_i), .hold_req_o(hold_req_o), .casc_req_o(casc_req_o),
        .ack_o(ack_o), .term_cnt_o(term_cnt_o), .tc_status_o(tc_status_o),
        .err_o(err_o), .mem_addr_o(mem_addr_o), .word_o(word_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .dev_data_i(dev_data_i),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .dev_data_o(dev_data_o),
        .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_type_i(cfg_type_i),
        .cfg_dec_i(cfg_dec_i), .cfg_auto_i(cfg_auto_i), .cfg_mask_i(cfg_mask_i),
        .cfg_addr_i(cfg_addr_i), .cfg_count_i(cfg_count_i), .cfg_page_i(cfg_page_i)
    );

    typedef struct {
        logic [7:0]  ack;
        logic [23:0] addr;
        logic        word, rd, wr, tc;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    function automatic exp_t mk(logic [7:0] a, logic [23:0] ad, logic w, logic r,
                                logic wr, logic t, logic [15:0] d, string tg);
        exp_t e;
        e.ack = a; e.addr = ad; e.word = w; e.rd = r; e.wr = wr; e.tc = t;
        e.data = d; e.tag = tg;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected transfer per acknowledge cycle and compare.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n === 1'b1 && ack_o !== 8'h00) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4: actual ack %h expected none", ack_o);
            end else begin
                e = q.pop_front();
                check({e.tag, " ack"},  ack_o,      e.ack);
                check({e.tag, " addr"}, mem_addr_o, e.addr);
                check({e.tag, " word"}, word_o,     e.word);
                check({e.tag, " rd"},   mem_rd_o,   e.rd);
                check({e.tag, " wr"},   mem_wr_o,   e.wr);
                check({e.tag, " tc"},   term_cnt_o, e.tc);
                if (e.wr) check({e.tag, " wdata"}, mem_wdata_o, e.data);
                if (e.rd) check({e.tag, " rdata"}, dev_data_o,  e.data);
            end
        end
    end

    task automatic cfg(input [3:0] ch, input [1:0] ty, input dec, input aut,
                       input msk, input [15:0] a, input [15:0] c, input [7:0] p);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_ch_i = ch; cfg_type_i = ty; cfg_dec_i = dec;
        cfg_auto_i = aut; cfg_mask_i = msk; cfg_addr_i = a; cfg_count_i = c;
        cfg_page_i = p;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // Driver: push the expected item, grant one hold, check the gap cycle.
    task automatic grant(input exp_t e);
        q.push_back(e);
        @(negedge clk); hold_ack_i = 1'b1;
        @(negedge clk); hold_ack_i = 1'b0;
        @(negedge clk); check("R4 gap hold_req", hold_req_o, 1'b0);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        req_i = '0; attached_i = 8'hFF; hold_ack_i = 1'b0;
        dev_data_i = 16'h77AB; mem_rdata_i = 16'hC3D4;
        cfg_we_i = 1'b0; cfg_ch_i = '0; cfg_type_i = '0; cfg_dec_i = 1'b0;
        cfg_auto_i = 1'b0; cfg_mask_i = 1'b0; cfg_addr_i = '0; cfg_count_i = '0;
        cfg_page_i = '0;
        do_reset();

        // R1 reset state
        check("R1 hold_req", hold_req_o, 1'b0);
        check("R1 casc_req", casc_req_o, 1'b0);
        check("R1 ack", ack_o, 8'h00);
        check("R1 term", term_cnt_o, 1'b0);
        check("R1 strobes", {mem_rd_o, mem_wr_o}, 2'b00);
        check("R1 tc_status", tc_status_o, 8'h00);
        check("R1 err", err_o, 1'b0);

        cfg(4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 16'h1234, 16'd2, 8'h05);
        cfg(4'd6, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0100, 16'd1, 8'h0A);
        cfg(4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 16'h0040, 16'd0, 8'h03);

        // R2 masked vs unmasked byte request
        req_i = 8'h04; @(negedge clk);
        check("R2 masked hold_req", hold_req_o, 1'b0);
        check("R2 masked casc_req", casc_req_o, 1'b0);
        req_i = 8'h02; @(negedge clk);
        check("R2 hold_req", hold_req_o, 1'b1);
        check("R2 casc_req", casc_req_o, 1'b1);

        // R3 byte channel 1 beats word channel 6; R7 stepping; R8 terminal count
        req_i = 8'h42;
        grant(mk(8'h12, 24'h051234, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00AB, "R3"));
        grant(mk(8'h12, 24'h051235, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00AB, "R7"));
        grant(mk(8'h12, 24'h051236, 1'b0, 1'b0, 1'b1, 1'b1, 16'h00AB, "R8"));
        // R9 channel 1 masked itself, channel 6 takes over; R5 word address; R10 reload
        grant(mk(8'h40, 24'h0A0200, 1'b1, 1'b1, 1'b0, 1'b0, 16'hC3D4, "R5"));
        grant(mk(8'h40, 24'h0A01FE, 1'b1, 1'b1, 1'b0, 1'b1, 16'hC3D4, "R10"));
        grant(mk(8'h40, 24'h0A0200, 1'b1, 1'b1, 1'b0, 1'b0, 16'hC3D4, "R10"));
        check("R8 tc_status", tc_status_o, 8'h42);
        req_i = 8'h02; @(negedge clk);
        check("R9 masked after expiry", hold_req_o, 1'b0);

        // R12 out-of-range load aliasing channel 1 must not unmask it
        cfg(4'd9, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd5, 8'h00);
        @(negedge clk);
        check("R12 hold_req", hold_req_o, 1'b0);
        check("R12 tc_status", tc_status_o, 8'h42);

        // R6 verify transfer: no strobes
        cfg(4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0040, 16'd0, 8'h03);
        req_i = 8'h04;
        grant(mk(8'h14, 24'h030040, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, "R6"));

        // R5 page OR shifted address; R6 word write; R3 channel 5 beats 6
        cfg(4'd5, 2'd1, 1'b0, 1'b0, 1'b0, 16'h8000, 16'd3, 8'h01);
        dev_data_i = 16'hBEEF;
        req_i = 8'h60;
        grant(mk(8'h20, 24'h010000, 1'b1, 1'b0, 1'b1, 1'b0, 16'hBEEF, "R5"));

        // R3 channel 0 beats 3 and 5; R7 downward stepping
        cfg(4'd0, 2'd1, 1'b1, 1'b0, 1'b0, 16'h0010, 16'd4, 8'h00);
        cfg(4'd3, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0300, 16'd4, 8'h00);
        req_i = 8'h29;
        grant(mk(8'h11, 24'h000010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00EF, "R3"));
        grant(mk(8'h11, 24'h00000F, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00EF, "R7"));
        req_i = 8'h00;
        check("R3 all expected transfers seen", q.size(), 0);

        // R11 request on the cascade slot
        @(negedge clk);
        req_i = 8'h10; @(negedge clk); @(negedge clk);
        check("R11 casc slot err", err_o, 1'b1);
        check("R11 casc slot ignored", hold_req_o, 1'b0);
        req_i = 8'h00; @(negedge clk); @(negedge clk);
        check("R11 sticky", err_o, 1'b1);

        // R11 request on an absent device
        do_reset();
        check("R1 err cleared", err_o, 1'b0);
        cfg(4'd7, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd1, 8'h00);
        attached_i = 8'h7F; req_i = 8'h80;
        @(negedge clk); @(negedge clk);
        check("R11 absent err", err_o, 1'b1);
        check("R11 absent ignored", hold_req_o, 1'b0);
        req_i = 8'h00;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule